// File: doc/BRIEF.md
# ADC Control Register Sequencer

This block holds the 8-bit control word of an analog-to-digital converter and enforces the order in which software may bring the converter up. Software writes either a whole byte or a single bit, and reads the word back. Each write is checked before it lands. A write that would run conversions with the comparator off is refused whole. So is a byte write that switches on the comparator and the run bit in one step. The mode and timing fields are frozen while the converter is enabled or running.

When the comparator is enabled, a stabilization counter starts. Its length is chosen by a channel-class input. If conversion is started before that wait has finished, the block marks the next conversion result as untrustworthy. It does this by suppressing the qualifier on the first conversion-done pulse that follows. Later pulses are passed on as valid results. The analog core and any hardware trigger lie outside the block.

Top module: `adc_ctl_seq`

## Requirements
- R1: After reset the control word reads 0x00, and comparator enable, run, settled and result_valid are all 0.
- R2: The word is laid out with run in bit 7, scan mode in bit 6 (0 single channel, 1 scan), the conversion clock select in bits 5:3, the timing level select in bits 2:1 and comparator enable in bit 0. Each field drives its own output.
- R3: A write whose result would have run = 1 with comparator enable = 0 is rejected, and the whole word stays unchanged.
- R4: A byte write that takes both run and comparator enable from 0 to 1 at once is rejected, and the word stays unchanged.
- R5: While run or comparator enable is 1, writes to the mode, clock select and level select fields are ignored, and the other bits of the same write still apply. When both are 0 these fields take the written value.
- R6: `settled` rises exactly N clock edges after the edge that sets comparator enable. N is taken from `chan_class`, which must be held stable while enabled: 00 high-accuracy, 01 standard, 10 internal sensor/reference, 11 test.
- R7: Clearing comparator enable drops `settled` and resets the counter, so a re-enable waits the full N again.
- R8: If run is set while `settled` is 0, the first conversion-done pulse afterwards gives no result_valid and later pulses do. If run is set after settling, the first pulse is valid.
- R9: result_valid is a one-cycle pulse on the edge after a conversion-done pulse that arrives while run is 1. A pulse that arrives with run at 0 gives nothing.
- R10: Read bit 7 returns the run bit when `wait_mode` is 0. When `wait_mode` is 1 it returns run OR (comparator enable AND NOT settled).
- R11: A single-bit write (`wr_bit` = 1) sets bit `wr_idx` to `wr_data[0]` and passes the same checks as a byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| wr_idx | input | 3 | Bit index for a single-bit write |
| wr_data | input | 8 | Byte to write, or bit value in bit 0 |
| chan_class | input | 2 | Channel class selecting the stabilization length |
| wait_mode | input | 1 | Selects the meaning of read bit 7 |
| conv_done | input | 1 | Conversion-done pulse from the converter |
| rd_data | output | 8 | Control word readback with status in bit 7 |
| cmp_en | output | 1 | Comparator enable |
| conv_run | output | 1 | Conversion run |
| scan_mode | output | 1 | Channel mode, 1 = scan |
| clk_sel | output | 3 | Conversion clock select |
| lvl_sel | output | 2 | Timing level select |
| settled | output | 1 | Stabilization wait complete |
| result_valid | output | 1 | Qualified conversion result strobe |

## Verification
The bench builds the block with short wait lengths: 4 cycles for high-accuracy, 6 for standard, 9 for internal and 3 for test. With those values the edge on which `settled` rises can be checked exactly for three classes. It also becomes practical to start conversion both before and after settling, which exercises the discard path in both outcomes. The short test-class wait lets a disable in mid-wait show whether the counter really restarts.

// File: rtl/adc_ctl_pkg.sv
`timescale 1ns/1ps
package adc_ctl_pkg;

    // Bit order of this struct is the register bit order (run = bit 7).
    typedef struct packed {
        logic       run;
        logic       scan;
        logic [2:0] clk_sel;
        logic [1:0] lvl_sel;
        logic       cmp_en;
    } ctl_reg_t;

    localparam int REG_W = $bits(ctl_reg_t);

    typedef enum logic [1:0] {
        CLS_HI_ACC = 2'b00,
        CLS_STD    = 2'b01,
        CLS_INTERN = 2'b10,
        CLS_TEST   = 2'b11
    } chan_class_e;

endpackage

// File: rtl/adc_ctl_wrchk.sv
`timescale 1ns/1ps
module adc_ctl_wrchk
    import adc_ctl_pkg::*;
#(
    parameter int IDX_W = $clog2(REG_W)
) (
    input  ctl_reg_t          cur,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [REG_W-1:0]  wr_data,
    output ctl_reg_t          nxt
);

    logic [REG_W-1:0] merged;
    ctl_reg_t         cand;
    logic             busy;
    logic             bad_run_off;
    logic             bad_dual_rise;

    always_comb begin
        merged = cur;
        if (wr_bit) begin
            merged[wr_idx] = wr_data[0];
        end else begin
            merged = wr_data;
        end

        cand = ctl_reg_t'(merged);
        busy = cur.run | cur.cmp_en;
        // Configuration fields are frozen while enabled or running
        if (busy) begin
            cand.scan    = cur.scan;
            cand.clk_sel = cur.clk_sel;
            cand.lvl_sel = cur.lvl_sel;
        end

        bad_run_off   = cand.run & ~cand.cmp_en;
        bad_dual_rise = cand.run & cand.cmp_en & ~cur.run & ~cur.cmp_en;

        if (wr_en && !bad_run_off && !bad_dual_rise) begin
            nxt = cand;
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/adc_ctl_stab.sv
`timescale 1ns/1ps
module adc_ctl_stab
    import adc_ctl_pkg::*;
#(
    parameter int STAB_HI   = 25,
    parameter int STAB_STD  = 50,
    parameter int STAB_INT  = 100,
    parameter int STAB_TEST = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_en,
    input  logic [1:0] chan_class,
    output logic       settled
);

    localparam int MAX_A  = (STAB_HI  > STAB_STD)  ? STAB_HI  : STAB_STD;
    localparam int MAX_B  = (STAB_INT > STAB_TEST) ? STAB_INT : STAB_TEST;
    localparam int MAX_N  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_N + 1);

    localparam logic [CNT_W-1:0] T_HI   = CNT_W'(STAB_HI);
    localparam logic [CNT_W-1:0] T_STD  = CNT_W'(STAB_STD);
    localparam logic [CNT_W-1:0] T_INT  = CNT_W'(STAB_INT);
    localparam logic [CNT_W-1:0] T_TEST = CNT_W'(STAB_TEST);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } stab_st_t;

    stab_st_t         st_d, st_q;
    logic [CNT_W-1:0] tgt;

    always_comb begin
        unique case (chan_class_e'(chan_class))
            CLS_HI_ACC: tgt = T_HI;
            CLS_STD:    tgt = T_STD;
            CLS_INTERN: tgt = T_INT;
            default:    tgt = T_TEST;
        endcase

        st_d = st_q;
        if (!cmp_en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < tgt) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        settled = cmp_en && (st_q.cnt >= tgt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/adc_ctl_qual.sv
`timescale 1ns/1ps
module adc_ctl_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic run_start,
    input  logic settled,
    input  logic conv_done,
    output logic result_valid
);

    typedef struct packed {
        logic discard;
        logic valid;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.valid = conv_done & run & ~st_q.discard;
        if (run_start) begin
            st_d.discard = ~settled;
        end else if (conv_done && run && st_q.discard) begin
            st_d.discard = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_valid = st_q.valid;

endmodule

// File: rtl/adc_ctl_seq.sv
`timescale 1ns/1ps
module adc_ctl_seq
    import adc_ctl_pkg::*;
#(
    parameter int STAB_HI   = 25,
    parameter int STAB_STD  = 50,
    parameter int STAB_INT  = 100,
    parameter int STAB_TEST = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_bit,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [1:0] chan_class,
    input  logic       wait_mode,
    input  logic       conv_done,
    output logic [7:0] rd_data,
    output logic       cmp_en,
    output logic       conv_run,
    output logic       scan_mode,
    output logic [2:0] clk_sel,
    output logic [1:0] lvl_sel,
    output logic       settled,
    output logic       result_valid
);

    ctl_reg_t ctl_d, ctl_q;
    logic     run_start;
    logic     status_bit;

    adc_ctl_wrchk #(.IDX_W(3)) u_wrchk (
        .cur     (ctl_q),
        .wr_en   (wr_en),
        .wr_bit  (wr_bit),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .nxt     (ctl_d)
    );

    adc_ctl_stab #(
        .STAB_HI   (STAB_HI),
        .STAB_STD  (STAB_STD),
        .STAB_INT  (STAB_INT),
        .STAB_TEST (STAB_TEST)
    ) u_stab (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_en     (ctl_q.cmp_en),
        .chan_class (chan_class),
        .settled    (settled)
    );

    adc_ctl_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (ctl_q.run),
        .run_start    (run_start),
        .settled      (settled),
        .conv_done    (conv_done),
        .result_valid (result_valid)
    );

    always_comb begin
        run_start  = ctl_d.run & ~ctl_q.run;
        status_bit = ctl_q.run;
        if (wait_mode) begin
            status_bit = ctl_q.run | (ctl_q.cmp_en & ~settled);
        end
        rd_data    = {status_bit, ctl_q.scan, ctl_q.clk_sel, ctl_q.lvl_sel, ctl_q.cmp_en};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmp_en    = ctl_q.cmp_en;
    assign conv_run  = ctl_q.run;
    assign scan_mode = ctl_q.scan;
    assign clk_sel   = ctl_q.clk_sel;
    assign lvl_sel   = ctl_q.lvl_sel;

endmodule

// File: rtl/adc_ctl_seq_chk.sv
`timescale 1ns/1ps
module adc_ctl_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmp_en,
    input logic       conv_run,
    input logic       scan_mode,
    input logic [2:0] clk_sel,
    input logic [1:0] lvl_sel,
    input logic       settled,
    input logic       conv_done,
    input logic       result_valid
);

    // R3: running with the comparator off never appears
    assert_no_run_without_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_run |-> cmp_en);

    // R4: both control bits never rise on one edge
    assert_no_dual_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !conv_run) |=> !(cmp_en && conv_run));

    // R5: configuration stays frozen while busy
    assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en || conv_run) |=> ($stable(scan_mode) && $stable(clk_sel) && $stable(lvl_sel)));

    // R7: disabling the comparator clears the settled state
    assert_settle_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> !settled || cmp_en);

    // R9: a valid result only follows a done pulse seen while running
    assert_valid_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(conv_done) && $past(conv_run)));

endmodule

bind adc_ctl_seq adc_ctl_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmp_en       (cmp_en),
    .conv_run     (conv_run),
    .scan_mode    (scan_mode),
    .clk_sel      (clk_sel),
    .lvl_sel      (lvl_sel),
    .settled      (settled),
    .conv_done    (conv_done),
    .result_valid (result_valid)
);

// File: tb/adc_ctl_seq_bench.sv
`timescale 1ns/1ps
module adc_ctl_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_bit = 1'b0;
    logic [2:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] chan_class = 2'b00;
    logic       wait_mode = 1'b0;
    logic       conv_done = 1'b0;
    logic [7:0] rd_data;
    logic       cmp_en, conv_run, scan_mode, settled, result_valid;
    logic [2:0] clk_sel;
    logic [1:0] lvl_sel;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    bit  exp_q[$];
    logic seen_done = 1'b0;

    always #10 clk = ~clk;

    adc_ctl_seq #(
        .STAB_HI(4), .STAB_STD(6), .STAB_INT(9), .STAB_TEST(3)
    ) u_adc_ctl_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
        .wr_idx(wr_idx), .wr_data(wr_data), .chan_class(chan_class),
        .wait_mode(wait_mode), .conv_done(conv_done), .rd_data(rd_data),
        .cmp_en(cmp_en), .conv_run(conv_run), .scan_mode(scan_mode),
        .clk_sel(clk_sel), .lvl_sel(lvl_sel), .settled(settled),
        .result_valid(result_valid)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr_byte(logic [7:0] v);
        wr_en = 1'b1; wr_bit = 1'b0; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_one(int idx, bit v);
        wr_en = 1'b1; wr_bit = 1'b1; wr_idx = 3'(idx); wr_data = {7'b0, v};
        @(negedge clk);
        wr_en = 1'b0; wr_bit = 1'b0;
    endtask

    task automatic pulse_done(bit exp);
        conv_done = 1'b1;
        exp_q.push_back(exp);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Scoreboard monitor: compares result_valid after each done pulse
    always @(posedge clk) seen_done <= conv_done;
    always @(negedge clk) begin
        if (seen_done && exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            check("R8/R9 result_valid", {7'b0, result_valid}, {7'b0, e});
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 reset word", rd_data, 8'h00);
        check("R1 outputs", {4'b0, cmp_en, conv_run, settled, result_valid}, 8'h00);

        // R2 field layout
        wr_byte(8'h6C);
        check("R2 readback", rd_data, 8'h6C);
        check("R2 fields", {1'b0, scan_mode, clk_sel, lvl_sel, cmp_en}, 8'h6C);

        // R3 run without comparator, byte and bit
        wr_byte(8'hEC);
        check("R3 byte reject", rd_data, 8'h6C);
        wr_one(7, 1'b1);
        check("R3/R11 bit reject", rd_data, 8'h6C);

        // R4 simultaneous rise
        wr_byte(8'hED);
        check("R4 dual rise reject", rd_data, 8'h6C);
        check("R4 run low", {7'b0, conv_run}, 8'h00);

        // R11 enable via single bit, class high-accuracy (4)
        chan_class = 2'b00;
        wr_one(0, 1'b1);
        check("R11 bit enable", rd_data, 8'h6D);
        wait_mode = 1'b1; #1;
        check("R10 wait status", {7'b0, rd_data[7]}, 8'h01);
        wait_mode = 1'b0; #1;
        check("R10 soft status", {7'b0, rd_data[7]}, 8'h00);

        // R5 field writes ignored while enabled
        wr_byte(8'h01);
        check("R5 byte fields frozen", rd_data, 8'h6D);
        wr_one(6, 1'b0);
        check("R5 bit field frozen", rd_data, 8'h6D);
        @(negedge clk);
        check("R6 not yet settled", {7'b0, settled}, 8'h00);
        @(negedge clk);
        check("R6 settled at 4", {7'b0, settled}, 8'h01);
        wait_mode = 1'b1; #1;
        check("R10 wait status settled", {7'b0, rd_data[7]}, 8'h00);
        wait_mode = 1'b0; #1;

        // R8 start after settling: first result valid
        wr_one(7, 1'b1);
        check("R2 run readback", rd_data, 8'hED);
        pulse_done(1'b1);
        pulse_done(1'b1);
        // R9 stop then done gives nothing
        wr_one(7, 1'b0);
        check("R9 stopped", rd_data, 8'h6D);
        pulse_done(1'b0);

        // R7 restart of the wait, class test (3)
        chan_class = 2'b11;
        wr_one(0, 1'b0);
        check("R7 disable drops settled", {7'b0, settled}, 8'h00);
        wr_one(0, 1'b1);
        repeat (2) @(negedge clk);
        wr_one(0, 1'b0);
        wr_one(0, 1'b1);
        repeat (2) @(negedge clk);
        check("R7 full wait restarted", {7'b0, settled}, 8'h00);
        @(negedge clk);
        check("R7 settled after restart", {7'b0, settled}, 8'h01);

        // R6 internal class (9)
        wr_one(0, 1'b0);
        chan_class = 2'b10;
        wr_one(0, 1'b1);
        repeat (8) @(negedge clk);
        check("R6 internal not settled", {7'b0, settled}, 8'h00);
        @(negedge clk);
        check("R6 internal settled at 9", {7'b0, settled}, 8'h01);

        // R8 early start with standard class (6)
        wr_one(0, 1'b0);
        chan_class = 2'b01;
        wr_one(0, 1'b1);
        wr_one(7, 1'b1);
        check("R8 early start accepted", rd_data, 8'hED);
        wait_mode = 1'b1; #1;
        check("R10 wait status running", {7'b0, rd_data[7]}, 8'h01);
        wait_mode = 1'b0; #1;
        pulse_done(1'b0);
        pulse_done(1'b1);
        pulse_done(1'b1);

        // R3 clearing enable while running is refused; R5 fields frozen
        wr_one(0, 1'b0);
        check("R3 disable while running", rd_data, 8'hED);
        wr_byte(8'h81);
        check("R5 frozen while running", rd_data, 8'hED);

        // Shut down, then fields writable again
        wr_byte(8'h00);
        check("R5 shutdown keeps fields", rd_data, 8'h6C);
        wr_byte(8'h12);
        check("R5 fields written when idle", rd_data, 8'h12);
        @(negedge clk);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule